// File: doc/BRIEF.md
# Masked Fractional Hamming Matcher

This block decides whether two binary biometric templates come from the same source. Each template has a companion mask that marks its trustworthy bits. The block finds the bit positions where the two templates disagree, keeps only the positions that both masks mark as valid, and counts them. It also counts how many positions are valid in both masks. The ratio of the two counts is the fractional distance. A lower distance means a closer match.

The distance is tested against a threshold given as a numerator and a denominator. The test uses cross-multiplication, so no divider is needed. The counting is a pipelined adder tree, and the threshold travels down the pipeline next to its own data. A new pair of templates can be accepted on every clock cycle, so a database scan can stream one stored template per cycle against a fixed probe.

Top module: `hm_matcher`

## Requirements
- R1: `diff_count` equals the number of set bits in `(tmpl_a ^ tmpl_b) & mask_a & mask_b` for the sample the result belongs to.
- R2: `valid_count` equals the number of set bits in `mask_a & mask_b` for the same sample.
- R3: `match` is 1 exactly when `valid_count` is not zero and `diff_count * thr_den < thr_num * valid_count`. The comparison is strict, so equality gives 0.
- R4: When `valid_count` is zero, `invalid` is 1 and `match` is 0. Otherwise `invalid` is 0.
- R5: A sample is accepted on every rising edge where `in_valid` is 1, including back-to-back edges. Each accepted sample produces exactly one result, in order, with `res_valid` high on the 8th rising edge after the accepting edge (LEVELS+1, where LEVELS = log2(WIDTH/CHUNK) = 7). Edges without `in_valid` produce no result. While `res_valid` is 0, `match` and `invalid` are 0.
- R6: The threshold pair is taken on the same edge as the templates. Changing `thr_num` or `thr_den` on later edges does not change that sample's result.
- R7: Template bits where either mask is 0 have no effect on `diff_count` or `match`.
- R8: The reset is synchronous and active-low. On an edge with `rst_n` at 0, `res_valid`, `match` and `invalid` go to 0, and samples still in flight are discarded.
- R9: Every bit position has equal weight, including bit 0 and bit WIDTH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample present this cycle |
| tmpl_a | input | WIDTH (2048) | Probe template |
| tmpl_b | input | WIDTH (2048) | Stored template |
| mask_a | input | WIDTH (2048) | Valid-bit mask of the probe |
| mask_b | input | WIDTH (2048) | Valid-bit mask of the stored template |
| thr_num | input | THR_W (16) | Threshold numerator |
| thr_den | input | THR_W (16) | Threshold denominator |
| res_valid | output | 1 | Result strobe |
| diff_count | output | CNT_W (12) | Masked disagreement count |
| valid_count | output | CNT_W (12) | Count of bits valid in both masks |
| match | output | 1 | Distance below threshold |
| invalid | output | 1 | No bit valid in both masks |

## Verification
The hardest case to reach is the exact equality boundary of the ratio test. Random templates almost never give `diff_count * thr_den` equal to `thr_num * valid_count`. The stimulus therefore builds templates with exactly 512 and exactly 511 differing bits under full masks, with the threshold set to 1/4, so the result lands on each side of the boundary.

Two other cases are built on purpose. One is a threshold change in the cycle right after a sample, while that sample is still in the pipeline. The other is a reset in the middle of a stream, used to show that in-flight results are dropped.

// File: rtl/hm_pkg.sv
`timescale 1ns/1ps
// hm_pkg: shared helpers for the masked Hamming matcher.
// Assumes widths are small enough for 32-bit elaboration arithmetic.
package hm_pkg;
    // Width of a counter able to hold the value 0..bits.
    function automatic int cnt_width(input int bits);
        return $clog2(bits + 1);
    endfunction
endpackage

// File: rtl/hm_popcount_tree.sv
`timescale 1ns/1ps
// hm_popcount_tree: pipelined population count of a WIDTH-bit vector.
// The leaves count CHUNK-bit slices. The partial sums are then added in a
// binary tree with one register level per tree level.
// Latency is LEVELS+1 edges from in_vec to cnt.
// Assumes WIDTH/CHUNK is a power of two and at least 2.
module hm_popcount_tree #(
    parameter int WIDTH = 2048,
    parameter int CHUNK = 16,
    localparam int CNT_W = hm_pkg::cnt_width(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] in_vec,
    output logic [CNT_W-1:0] cnt
);
    localparam int NCHUNK = WIDTH / CHUNK;
    localparam int NODES  = 2 * NCHUNK - 1;
    localparam int LEAF0  = NCHUNK - 1;

    logic [CNT_W-1:0] node_q [NODES];
    logic [CNT_W-1:0] node_d [NODES];

    // Count the set bits of one slice.
    function automatic logic [CNT_W-1:0] slice_pop(input logic [CHUNK-1:0] v);
        logic [CNT_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < CHUNK; i++) acc = acc + CNT_W'(v[i]);
        return acc;
    endfunction

    // Next values: leaves from the input slices, inner nodes from their children.
    always_comb begin
        for (int c = 0; c < NCHUNK; c++)
            node_d[LEAF0 + c] = slice_pop(in_vec[c*CHUNK +: CHUNK]);
        for (int n = 0; n < LEAF0; n++)
            node_d[n] = node_q[2*n + 1] + node_q[2*n + 2];
    end

    // Register every tree node, so each level is one pipeline stage.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NODES; i++) begin
            if (!rst_n) node_q[i] <= '0;
            else        node_q[i] <= node_d[i];
        end
    end

    assign cnt = node_q[0];

    // R2: a count never exceeds the vector width
    pop_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(WIDTH));
endmodule

// File: rtl/hm_ratio_cmp.sv
`timescale 1ns/1ps
// hm_ratio_cmp: final stage. Tests diff/valid < num/den by cross-multiplying
// and registers the result.
// Assumes its inputs are already aligned to the same sample.
// An empty valid set forces no match and raises invalid.
module hm_ratio_cmp #(
    parameter int CNT_W = 12,
    parameter int THR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [CNT_W-1:0] diff_cnt,
    input  logic [CNT_W-1:0] valid_cnt,
    input  logic [THR_W-1:0] thr_num,
    input  logic [THR_W-1:0] thr_den,
    output logic             res_valid,
    output logic [CNT_W-1:0] diff_count,
    output logic [CNT_W-1:0] valid_count,
    output logic             match,
    output logic             invalid
);
    localparam int PROD_W = CNT_W + THR_W;

    logic [PROD_W-1:0] lhs;
    logic [PROD_W-1:0] rhs;
    logic              empty;

    // Cross products that stand in for the division.
    assign lhs   = {{THR_W{1'b0}}, diff_cnt}  * {{CNT_W{1'b0}}, thr_den};
    assign rhs   = {{CNT_W{1'b0}}, thr_num}   * {{THR_W{1'b0}}, valid_cnt};
    assign empty = (valid_cnt == '0);

    // Register the decision and the counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            diff_count  <= '0;
            valid_count <= '0;
            match       <= 1'b0;
            invalid     <= 1'b0;
        end else begin
            res_valid   <= in_valid;
            diff_count  <= diff_cnt;
            valid_count <= valid_cnt;
            match       <= in_valid && !empty && (lhs < rhs);
            invalid     <= in_valid && empty;
        end
    end

    // R3: match is only ever raised together with a result
    match_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> res_valid);

    // R4: an empty valid set gives invalid and never a match
    empty_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && (valid_count == '0) |-> invalid && !match);
endmodule

// File: rtl/hm_matcher.sv
`timescale 1ns/1ps
// hm_matcher: masked fractional Hamming matcher (top).
// Forms the masked difference and the joint mask, counts both in parallel
// trees, and carries the valid bit and the threshold alongside them.
// Accepts one sample per clock. Result latency is LEVELS+1 edges.
// Assumes WIDTH/CHUNK is a power of two and at least 2.
module hm_matcher #(
    parameter int WIDTH = 2048,
    parameter int CHUNK = 16,
    parameter int THR_W = 16,
    localparam int CNT_W = hm_pkg::cnt_width(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] tmpl_a,
    input  logic [WIDTH-1:0] tmpl_b,
    input  logic [WIDTH-1:0] mask_a,
    input  logic [WIDTH-1:0] mask_b,
    input  logic [THR_W-1:0] thr_num,
    input  logic [THR_W-1:0] thr_den,
    output logic             res_valid,
    output logic [CNT_W-1:0] diff_count,
    output logic [CNT_W-1:0] valid_count,
    output logic             match,
    output logic             invalid
);
    localparam int LEVELS = $clog2(WIDTH / CHUNK);
    localparam int TREE_LAT = LEVELS + 1;

    logic [WIDTH-1:0] both_ok;
    logic [WIDTH-1:0] masked_diff;
    logic [CNT_W-1:0] diff_cnt;
    logic [CNT_W-1:0] valid_cnt;

    logic             vld_pipe [TREE_LAT];
    logic [THR_W-1:0] num_pipe [TREE_LAT];
    logic [THR_W-1:0] den_pipe [TREE_LAT];

    // Bits valid in both masks, and disagreements kept only there.
    assign both_ok     = mask_a & mask_b;
    assign masked_diff = (tmpl_a ^ tmpl_b) & both_ok;

    hm_popcount_tree #(.WIDTH(WIDTH), .CHUNK(CHUNK)) diff_tree_i (
        .clk(clk), .rst_n(rst_n), .in_vec(masked_diff), .cnt(diff_cnt));

    hm_popcount_tree #(.WIDTH(WIDTH), .CHUNK(CHUNK)) valid_tree_i (
        .clk(clk), .rst_n(rst_n), .in_vec(both_ok), .cnt(valid_cnt));

    // Delay the valid bit and the threshold to line up with the tree outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TREE_LAT; i++) begin
                vld_pipe[i] <= 1'b0;
                num_pipe[i] <= '0;
                den_pipe[i] <= '0;
            end
        end else begin
            vld_pipe[0] <= in_valid;
            num_pipe[0] <= thr_num;
            den_pipe[0] <= thr_den;
            for (int i = 1; i < TREE_LAT; i++) begin
                vld_pipe[i] <= vld_pipe[i-1];
                num_pipe[i] <= num_pipe[i-1];
                den_pipe[i] <= den_pipe[i-1];
            end
        end
    end

    hm_ratio_cmp #(.CNT_W(CNT_W), .THR_W(THR_W)) cmp_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(vld_pipe[TREE_LAT-1]),
        .diff_cnt(diff_cnt), .valid_cnt(valid_cnt),
        .thr_num(num_pipe[TREE_LAT-1]), .thr_den(den_pipe[TREE_LAT-1]),
        .res_valid(res_valid), .diff_count(diff_count), .valid_count(valid_count),
        .match(match), .invalid(invalid));

    // R1: masked disagreements can never outnumber the jointly valid bits
    count_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> diff_count <= valid_count);

    // R8: a reset edge leaves the outputs idle
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> !res_valid && !match && !invalid);
endmodule

// File: tb/hm_matcher_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference pipeline, compared on every clock.
module hm_matcher_tb_top;
    localparam int W     = 2048;
    localparam int CH    = 16;
    localparam int TW    = 16;
    localparam int CW    = $clog2(W + 1);
    localparam int LAT   = $clog2(W / CH) + 1;

    typedef struct {
        bit     v;
        longint d;
        longint n;
        bit     m;
        bit     inv;
        string  tag;
    } rec_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [W-1:0]  tmpl_a = '0, tmpl_b = '0, mask_a = '0, mask_b = '0;
    logic [TW-1:0] thr_num = '0, thr_den = 16'd1;
    logic          res_valid, match, invalid;
    logic [CW-1:0] diff_count, valid_count;

    string tag_in = "";
    rec_t  mdl [LAT+1];
    int    n_chk = 0, n_fail = 0;
    bit    started = 0;

    hm_matcher #(.WIDTH(W), .CHUNK(CH), .THR_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .tmpl_a(tmpl_a), .tmpl_b(tmpl_b), .mask_a(mask_a), .mask_b(mask_b),
        .thr_num(thr_num), .thr_den(thr_den),
        .res_valid(res_valid), .diff_count(diff_count), .valid_count(valid_count),
        .match(match), .invalid(invalid));

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Reference model: one entry per edge. Entry LAT is the result due now.
    always @(posedge clk) begin
        rec_t r;
        longint d, n;
        started = 1;
        for (int i = LAT; i > 0; i--) mdl[i] = mdl[i-1];
        d = 0; n = 0;
        for (int i = 0; i < W; i++) begin
            if (mask_a[i] && mask_b[i]) begin
                n++;
                if (tmpl_a[i] != tmpl_b[i]) d++;
            end
        end
        r.v = rst_n && in_valid; r.d = d; r.n = n; r.tag = tag_in;
        r.inv = (n == 0);
        r.m = (n != 0) && (d * longint'(thr_den) < longint'(thr_num) * n);
        mdl[0] = r;
        if (!rst_n) for (int i = 0; i <= LAT; i++) mdl[i].v = 0;
    end

    // Compare with the reference model, away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            chk(res_valid == mdl[LAT].v, "R5 res_valid timing", res_valid, mdl[LAT].v);
            if (mdl[LAT].v) begin
                chk(diff_count == mdl[LAT].d, {"R1 diff_count ", mdl[LAT].tag}, diff_count, mdl[LAT].d);
                chk(valid_count == mdl[LAT].n, {"R2 valid_count ", mdl[LAT].tag}, valid_count, mdl[LAT].n);
                chk(match == mdl[LAT].m, {"R3 match ", mdl[LAT].tag}, match, mdl[LAT].m);
                chk(invalid == mdl[LAT].inv, {"R4 invalid ", mdl[LAT].tag}, invalid, mdl[LAT].inv);
            end else begin
                chk(!match && !invalid, "R5 flags idle without result", {match, invalid}, 0);
            end
        end
    end

    function automatic logic [W-1:0] rnd_vec();
        logic [W-1:0] v;
        for (int i = 0; i < W/32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic send(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [W-1:0] ma, input logic [W-1:0] mb,
                        input int num, input int den, input string tag);
        tmpl_a = a; tmpl_b = b; mask_a = ma; mask_b = mb;
        thr_num = TW'(num); thr_den = TW'(den); tag_in = tag; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int cycles);
        in_valid = 1'b0;
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        logic [W-1:0] ones, a, m, b, lowbits;
        ones = '1;
        repeat (3) @(negedge clk);
        chk(!res_valid && !match && !invalid, "R8 outputs low in reset", {res_valid, match, invalid}, 0);
        rst_n = 1'b1;
        idle(1);

        a = rnd_vec();
        send(a, a, ones, ones, 1, 4, "R1 identical");
        send(a, ~a, ones, ones, 1, 4, "R3 all differ");
        send(a, ~a, '0, '0, 1, 4, "R4 empty masks");
        m = rnd_vec();
        send(a, ~a, m, ~m, 1, 4, "R4 disjoint masks");
        m = rnd_vec(); b = a ^ ~(m & ones);
        send(a, b, m, m, 1, 4, "R7 differences outside mask");
        b = rnd_vec();
        send(a, b, m, rnd_vec(), 1, 2, "R7 partial masks");
        lowbits = '0; lowbits[511:0] = '1;
        send(a, a ^ lowbits, ones, ones, 1, 4, "R3 equal ratio no match");
        lowbits[511] = 1'b0;
        send(a, a ^ lowbits, ones, ones, 1, 4, "R3 just below ratio");
        lowbits = '0; lowbits[0] = 1'b1;
        send(a, a ^ lowbits, lowbits, lowbits, 1, 2, "R9 bit 0");
        lowbits = '0; lowbits[W-1] = 1'b1;
        send(a, a ^ lowbits, lowbits, lowbits, 1, 2, "R9 top bit");
        idle(LAT + 1);

        // Threshold changes while the sample is still in flight.
        lowbits = '0; lowbits[99:0] = '1;
        send(a, a ^ lowbits, ones, ones, 1, 2, "R6 held threshold");
        thr_num = '0; thr_den = 16'd1;
        idle(LAT + 1);

        // Back-to-back stream with random thresholds.
        for (int k = 0; k < 40; k++)
            send(rnd_vec(), rnd_vec(), rnd_vec() | rnd_vec(), rnd_vec() | rnd_vec(),
                 $urandom_range(0, 15), $urandom_range(1, 15), "R5 stream");
        // Sparse traffic with gaps.
        for (int k = 0; k < 10; k++) begin
            send(rnd_vec(), rnd_vec(), rnd_vec(), rnd_vec(),
                 $urandom_range(0, 15), $urandom_range(1, 15), "R5 gapped");
            idle($urandom_range(0, 3));
        end
        idle(LAT + 1);

        // Reset in the middle of a stream drops in-flight samples.
        for (int k = 0; k < 3; k++)
            send(rnd_vec(), rnd_vec(), ones, ones, 1, 3, "R8 flushed");
        rst_n = 1'b0;
        @(negedge clk);
        chk(!res_valid && !match && !invalid, "R8 outputs low after reset edge", {res_valid, match, invalid}, 0);
        rst_n = 1'b1;
        idle(LAT + 2);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule